// File: doc/BRIEF.md
# SDRAM Controller Data Path with Byte Masks

This block sits between a single-data-rate SDRAM controller's command sequencer and the memory's data and mask pins. When the sequencer signals a write, the block launches one data word and its byte-mask pair per clock for the programmed number of beats. The DQ output enable is raised only for those beats, and the mask has no delay with respect to the data. When the sequencer signals a read, the block schedules the read byte masks. A mask takes effect at the memory two clocks after it is sampled, so the block launches it early enough to float exactly the intended beat. The block then captures each returning word once the selected CAS latency has elapsed and passes it to the user with a valid strobe and per-byte masked flags.

The issue strobes are sampled one edge before the controller's command appears on the memory pins. All outputs are registered, so a launched beat lines up with a registered command. The CAS latency select is expected to stay constant while reads are in flight. The burst-length code is taken at each issue.

Top module: `sdram_dq_path`

## Requirements
- R1: While `rst_n` is low, `dq_oe`, `dq_out`, `dqm`, `rd_valid`, `rd_data` and `rd_masked` are all zero.
- R2: A write beat whose data and mask are presented at edge k appears on `dq_out` and `dqm`, with `dq_oe` high, in the cycle after edge k. The first beat is presented with `wr_issue`, and the following beats on the following edges.
- R3: `cfg_bl` codes 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats for both reads and writes. No beat is produced beyond the burst.
- R4: `cfg_cl3` = 0 selects CAS latency 2 and 1 selects latency 3. Read beat i of a burst whose `rd_issue` was sampled at edge k is taken from `dq_in` at edge k+1+CL+i, and it shows on `rd_data` with `rd_valid` high in the next cycle.
- R5: The `rd_mask` pair given with read beat i is driven on `dqm` during the cycle that ends at edge k+CL-1+i, which is two edges before that beat's data is due.
- R6: A read beat with any mask bit set still raises `rd_valid`. Its `rd_masked` bits equal its mask, and its masked bytes of `rd_data` read as zero.
- R7: `dq_oe` is low for the cycle in which each read word is taken from `dq_in` and for the cycle before it. A write beat sampled on the same edge as a read beat, or within the CL edges after one, is withheld: `dq_oe` stays low and `dq_out` stays zero.
- R8: An issue strobe seen while a burst of the same direction is still running ends that burst and starts the new one at that edge.
- R9: Mask bit 0 governs data bits 7:0, and mask bit 1 governs bits 15:8, in both directions.
- R10: Whenever `dq_oe` is low, `dq_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cl3 | input | 1 | CAS latency select: 0 gives 2 clocks, 1 gives 3 clocks |
| cfg_bl | input | 2 | Burst-length code: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8 |
| wr_issue | input | 1 | Write command strobe, one edge ahead of the command pins |
| wr_data | input | 16 | Write word for the current beat |
| wr_mask | input | 2 | Write byte mask for the current beat; a 1 blocks that byte |
| rd_issue | input | 1 | Read command strobe, one edge ahead of the command pins |
| rd_mask | input | 2 | Read byte mask for the current read beat; a 1 floats that byte |
| dq_in | input | 16 | Data sampled from the memory data pins |
| dq_oe | output | 1 | Data pin output enable |
| dq_out | output | 16 | Value driven on the data pins |
| dqm | output | 2 | Byte-mask pins |
| rd_valid | output | 1 | Read word valid toward the user |
| rd_data | output | 16 | Captured read word, masked bytes zero |
| rd_masked | output | 2 | Per-byte masked flags for the current read word |

## Verification
The hardest case to reach from the ports is a write that overlaps a read still in flight. Some of the write's beats fall inside the bus turnaround window and must be withheld, while its later beats must go out normally, and the read's two-clock-early masks must still reach `dqm` untouched. The bench starts a four-beat read at latency 3 and, in parallel, starts a write five edges later. The write's first two beats land inside the window and the last two land after it. A small memory model replays the read data, floating each byte whose mask it saw two edges earlier. Truncating bursts and gapless back-to-back reads are driven in the same way.

// File: rtl/sdp_pkg.sv
// Shared definitions for the SDRAM data path.
// Assumes burst lengths are limited to 1, 2, 4 and 8 beats.
package sdp_pkg;

    localparam int unsigned BL_CODE_W = 2;
    localparam int unsigned BEAT_CNT_W = 3;

    typedef enum logic [BL_CODE_W-1:0] {
        BURST_1 = 2'd0,
        BURST_2 = 2'd1,
        BURST_4 = 2'd2,
        BURST_8 = 2'd3
    } burst_code_e;

    // Beats remaining after the first one, for a burst-length code.
    function automatic logic [BEAT_CNT_W-1:0] extra_beats(input logic [BL_CODE_W-1:0] code);
        case (burst_code_e'(code))
            BURST_1: extra_beats = 3'd0;
            BURST_2: extra_beats = 3'd1;
            BURST_4: extra_beats = 3'd3;
            default: extra_beats = 3'd7;
        endcase
    endfunction

endpackage

// File: rtl/sdp_burst_seq.sv
// Burst beat generator: marks every clock that carries a beat of the
// current burst. A new issue restarts the count, which truncates the
// burst in flight. Assumes the code is valid while issue is high.
module sdp_burst_seq
    import sdp_pkg::*;
#(
    parameter int unsigned CNT_W = BEAT_CNT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue,
    input  logic [BL_CODE_W-1:0] bl_code,
    output logic                 beat
);

    logic [CNT_W-1:0] remain_q;

    // Count the beats still owed after the issuing clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (issue) begin
            remain_q <= CNT_W'(extra_beats(bl_code));
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign beat = issue | (remain_q != '0);

endmodule

// File: rtl/sdp_rd_path.sv
// Read side: delays the read-beat marks and masks, returns the next
// value the mask pins need for reads (two clocks ahead of the data),
// raises the turnaround hold-off for the write side, and captures
// dq_in after the CAS latency. Assumes cl3 is stable during reads.
module sdp_rd_path #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned MAX_CL = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       beat,
    input  logic [DATA_W/BYTE_W-1:0]   rd_mask,
    input  logic                       cl3,
    input  logic [DATA_W-1:0]          dq_in,
    output logic [DATA_W/BYTE_W-1:0]   rd_dqm,
    output logic                       hold_off,
    output logic                       rd_valid,
    output logic [DATA_W-1:0]          rd_data,
    output logic [DATA_W/BYTE_W-1:0]   rd_masked
);

    localparam int unsigned MASK_W = DATA_W / BYTE_W;
    localparam int unsigned DEPTH  = MAX_CL + 1;

    logic [DEPTH-1:0]  vld_pipe;
    logic [MASK_W-1:0] msk_pipe [DEPTH];
    logic [MASK_W-1:0] beat_mask;
    logic              cap_vld;
    logic [MASK_W-1:0] cap_msk;

    assign beat_mask = beat ? rd_mask : '0;

    // Shift the beat marks and their masks one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_pipe <= '0;
            for (int s = 0; s < DEPTH; s++) msk_pipe[s] <= '0;
        end else begin
            vld_pipe    <= {vld_pipe[DEPTH-2:0], beat};
            msk_pipe[0] <= beat_mask;
            for (int s = 1; s < DEPTH; s++) msk_pipe[s] <= msk_pipe[s-1];
        end
    end

    // Pick the stage that lines up with the data edge for the latency.
    assign cap_vld = cl3 ? vld_pipe[MAX_CL]   : vld_pipe[MAX_CL-1];
    assign cap_msk = cl3 ? msk_pipe[MAX_CL]   : msk_pipe[MAX_CL-1];

    // Mask pins act two clocks early: latency 2 needs the live mask.
    assign rd_dqm = cl3 ? msk_pipe[0] : beat_mask;

    // Bus belongs to the memory from CL-1 clocks after a read beat.
    assign hold_off = beat | vld_pipe[0] | vld_pipe[1] | (cl3 & vld_pipe[2]);

    // Register the valid strobe and the masked flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid  <= 1'b0;
            rd_masked <= '0;
        end else begin
            rd_valid  <= cap_vld;
            rd_masked <= cap_vld ? cap_msk : '0;
        end
    end

    for (genvar b = 0; b < MASK_W; b++) begin : g_lane
        // Capture one byte lane, zeroing it when floated or idle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_data[b*BYTE_W +: BYTE_W] <= '0;
            end else if (cap_vld && !cap_msk[b]) begin
                rd_data[b*BYTE_W +: BYTE_W] <= dq_in[b*BYTE_W +: BYTE_W];
            end else begin
                rd_data[b*BYTE_W +: BYTE_W] <= '0;
            end
        end
    end

endmodule

// File: rtl/sdp_wr_path.sv
// Write side and pin registers: launches each write beat with its mask
// on the next clock, and otherwise releases the bus and passes the read
// mask schedule to the mask pins. Assumes hold_off covers every clock
// in which the memory may drive the bus.
module sdp_wr_path #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned BYTE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     beat,
    input  logic                     hold_off,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [DATA_W/BYTE_W-1:0] wr_mask,
    input  logic [DATA_W/BYTE_W-1:0] rd_dqm,
    output logic                     dq_oe,
    output logic [DATA_W-1:0]        dq_out,
    output logic [DATA_W/BYTE_W-1:0] dqm
);

    logic launch;

    assign launch = beat & ~hold_off;

    // Load the pin registers from a write beat or from the read schedule.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_oe  <= 1'b0;
            dq_out <= '0;
            dqm    <= '0;
        end else if (launch) begin
            dq_oe  <= 1'b1;
            dq_out <= wr_data;
            dqm    <= wr_mask;
        end else begin
            dq_oe  <= 1'b0;
            dq_out <= '0;
            dqm    <= rd_dqm;
        end
    end

endmodule

// File: rtl/sdram_dq_path.sv
// SDRAM data path top: one burst generator per direction, the read
// capture side and the write/pin side. Assumes issue strobes lead the
// command pins by one clock and cfg_cl3 changes only while idle.
module sdram_dq_path
    import sdp_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned BYTE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_cl3,
    input  logic [BL_CODE_W-1:0]     cfg_bl,
    input  logic                     wr_issue,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [DATA_W/BYTE_W-1:0] wr_mask,
    input  logic                     rd_issue,
    input  logic [DATA_W/BYTE_W-1:0] rd_mask,
    input  logic [DATA_W-1:0]        dq_in,
    output logic                     dq_oe,
    output logic [DATA_W-1:0]        dq_out,
    output logic [DATA_W/BYTE_W-1:0] dqm,
    output logic                     rd_valid,
    output logic [DATA_W-1:0]        rd_data,
    output logic [DATA_W/BYTE_W-1:0] rd_masked
);

    localparam int unsigned MASK_W = DATA_W / BYTE_W;

    logic              wr_beat;
    logic              rd_beat;
    logic              rd_hold;
    logic [MASK_W-1:0] rd_dqm;

    sdp_burst_seq i_wr_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .issue   (wr_issue),
        .bl_code (cfg_bl),
        .beat    (wr_beat)
    );

    sdp_burst_seq i_rd_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .issue   (rd_issue),
        .bl_code (cfg_bl),
        .beat    (rd_beat)
    );

    sdp_rd_path #(
        .DATA_W (DATA_W),
        .BYTE_W (BYTE_W)
    ) i_rd_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat      (rd_beat),
        .rd_mask   (rd_mask),
        .cl3       (cfg_cl3),
        .dq_in     (dq_in),
        .rd_dqm    (rd_dqm),
        .hold_off  (rd_hold),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .rd_masked (rd_masked)
    );

    sdp_wr_path #(
        .DATA_W (DATA_W),
        .BYTE_W (BYTE_W)
    ) i_wr_path (
        .clk      (clk),
        .rst_n    (rst_n),
        .beat     (wr_beat),
        .hold_off (rd_hold),
        .wr_data  (wr_data),
        .wr_mask  (wr_mask),
        .rd_dqm   (rd_dqm),
        .dq_oe    (dq_oe),
        .dq_out   (dq_out),
        .dqm      (dqm)
    );

endmodule

// File: rtl/sdram_dq_path_chk.sv
// Property checker for sdram_dq_path, attached by bind below.
// Assumes cfg_cl3 is held constant while reads are in flight.
module sdram_dq_path_chk #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned BYTE_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cfg_cl3,
    input logic                     rd_issue,
    input logic [DATA_W/BYTE_W-1:0] rd_mask,
    input logic                     wr_beat,
    input logic                     rd_hold,
    input logic                     dq_oe,
    input logic [DATA_W-1:0]        dq_out,
    input logic [DATA_W/BYTE_W-1:0] dqm,
    input logic                     rd_valid,
    input logic [DATA_W-1:0]        rd_data,
    input logic [DATA_W/BYTE_W-1:0] rd_masked
);

    localparam int unsigned MASK_W = DATA_W / BYTE_W;

    AST_FIRST_BEAT_CL2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_cl3 && $past(rd_issue, 4)) |-> rd_valid); // R4
    AST_FIRST_BEAT_CL3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_cl3 && $past(rd_issue, 5)) |-> rd_valid); // R4
    AST_RD_MASK_EARLY_CL2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_cl3 && $past(rd_issue)) |-> dqm == $past(rd_mask)); // R5
    AST_RD_MASK_EARLY_CL3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_cl3 && $past(rd_issue, 2)) |-> dqm == $past(rd_mask, 2)); // R5
    AST_BUS_FREE_AT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (!$past(dq_oe) && !$past(dq_oe, 2))); // R7
    AST_WRITE_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_beat && !rd_hold) |-> dq_oe); // R2
    AST_WRITE_WITHHELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_hold) |-> !dq_oe); // R7
    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> dq_out == '0); // R10
    AST_MASK_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_masked != '0) |-> rd_valid); // R6

    for (genvar b = 0; b < MASK_W; b++) begin : g_lane
        AST_MASKED_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            rd_masked[b] |-> rd_data[b*BYTE_W +: BYTE_W] == '0); // R6
    end

endmodule

bind sdram_dq_path sdram_dq_path_chk #(
    .DATA_W (DATA_W),
    .BYTE_W (BYTE_W)
) i_sdram_dq_path_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_cl3   (cfg_cl3),
    .rd_issue  (rd_issue),
    .rd_mask   (rd_mask),
    .wr_beat   (wr_beat),
    .rd_hold   (rd_hold),
    .dq_oe     (dq_oe),
    .dq_out    (dq_out),
    .dqm       (dqm),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .rd_masked (rd_masked)
);

// File: tb/test_sdram_dq_path.sv
`timescale 1ns/1ps
// Bench for sdram_dq_path: sweeps latency, burst length and mask
// patterns. A memory model replays read data, and expected pin and
// user values are scheduled by absolute cycle.
module test_sdram_dq_path;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_cl3 = 1'b0;
    logic [1:0]  cfg_bl = 2'd0;
    logic        wr_issue = 1'b0;
    logic [15:0] wr_data = '0;
    logic [1:0]  wr_mask = '0;
    logic        rd_issue = 1'b0;
    logic [1:0]  rd_mask = '0;
    logic [15:0] dq_in = '0;
    logic        dq_oe;
    logic [15:0] dq_out;
    logic [1:0]  dqm;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic [1:0]  rd_masked;

    sdram_dq_path i_sdram_dq_path (
        .clk(clk), .rst_n(rst_n), .cfg_cl3(cfg_cl3), .cfg_bl(cfg_bl),
        .wr_issue(wr_issue), .wr_data(wr_data), .wr_mask(wr_mask),
        .rd_issue(rd_issue), .rd_mask(rd_mask), .dq_in(dq_in),
        .dq_oe(dq_oe), .dq_out(dq_out), .dqm(dqm),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_masked(rd_masked)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int cl = 2;
    bit run_chk = 1'b0;
    bit done = 1'b0;

    // Expectation tables, indexed by cycle modulo 1024.
    bit          ew_v [1024];
    logic [15:0] ew_d [1024];
    logic [1:0]  ew_m [1024];
    bit          em_v [1024];
    logic [1:0]  em_m [1024];
    bit          er_v [1024];
    logic [15:0] er_d [1024];
    logic [1:0]  er_m [1024];
    bit          dv_v [1024];
    logic [15:0] dv_d [1024];
    logic [1:0]  dqm_h [1024];
    bit          rh [1024];
    int lw_c = 0, lw_n = 0, lr_c = 0, lr_n = 0, lr_cl = 2;

    function automatic int ix(input int t);
        return t & 1023;
    endfunction

    function automatic int nbeats(input logic [1:0] code);
        return 1 << ((code == 2'd3) ? 3 : int'(code));
    endfunction

    function automatic logic [15:0] wgen(input int seed, input int i);
        return {8'(seed ^ (i * 17)), 8'(seed + i)};
    endfunction

    function automatic logic [15:0] rgen(input int tag, input int i);
        return {8'(tag + i * 5), 8'((tag * 3) ^ i)};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Cycle counter, advanced on every rising edge.
    always @(posedge clk) cyc <= cyc + 1;

    // Memory model and per-cycle comparison, run mid-cycle.
    always @(negedge clk) begin
        if (run_chk) begin
            int t;
            logic [15:0] d;
            t = cyc;
            dqm_h[ix(t)] = dqm;
            if (dv_v[ix(t)]) begin
                d = dv_d[ix(t)];
                for (int b = 0; b < 2; b++)
                    if (dqm_h[ix(t - 2)][b]) d[b*8 +: 8] = 8'hA5;
                dq_in = d;
            end else begin
                dq_in = 16'h5A5A;
            end
            if (ew_v[ix(t)]) begin
                chk(dq_oe && dq_out == ew_d[ix(t)] && dqm == ew_m[ix(t)], "R2 R9 write beat",
                    {13'd0, dq_oe, dqm, dq_out}, {13'd0, 1'b1, ew_m[ix(t)], ew_d[ix(t)]});
            end else begin
                chk(!dq_oe && dq_out == 16'h0, "R3 R7 R10 no write beat",
                    {15'd0, dq_oe, dq_out}, 32'd0);
            end
            if (em_v[ix(t)]) begin
                chk(dqm == em_m[ix(t)], "R5 read mask", 32'(dqm), 32'(em_m[ix(t)]));
            end else if (!ew_v[ix(t)]) begin
                chk(dqm == 2'b00, "R5 idle mask", 32'(dqm), 32'd0);
            end
            if (er_v[ix(t)]) begin
                chk(rd_valid && rd_data == er_d[ix(t)] && rd_masked == er_m[ix(t)], "R4 R6 R9 read beat",
                    {13'd0, rd_valid, rd_masked, rd_data}, {13'd0, 1'b1, er_m[ix(t)], er_d[ix(t)]});
            end else begin
                chk(!rd_valid, "R3 R4 no read beat", 32'(rd_valid), 32'd0);
            end
            dv_v[ix(t)] = 1'b0;
            ew_v[ix(t)] = 1'b0;
            em_v[ix(t)] = 1'b0;
            er_v[ix(t)] = 1'b0;
            rh[ix(t - 12)] = 1'b0;
        end
    end

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            wr_issue = 1'b0;
            rd_issue = 1'b0;
            wr_mask = '0;
            rd_mask = '0;
        end
    endtask

    // Write burst; n_drive below the burst length leaves it to be cut short (R8).
    task automatic wr_burst(input logic [1:0] code, input logic [15:0] mp, input int n_drive, input int seed);
        int bl;
        bl = nbeats(code);
        for (int k = 0; k < n_drive; k++) begin
            @(negedge clk);
            if (k == 0) begin
                int c;
                c = cyc;
                for (int i = 0; i < lw_n; i++)
                    if (lw_c + i >= c) ew_v[ix(lw_c + 1 + i)] = 1'b0;
                for (int i = 0; i < bl; i++) begin
                    bit blocked;
                    blocked = 1'b0;
                    for (int j = 0; j <= cl; j++) if (rh[ix(c + i - j)]) blocked = 1'b1;
                    if (!blocked) begin
                        ew_v[ix(c + 1 + i)] = 1'b1;
                        ew_d[ix(c + 1 + i)] = wgen(seed, i);
                        ew_m[ix(c + 1 + i)] = mp[2*i +: 2];
                    end
                end
                lw_c = c;
                lw_n = bl;
                cfg_bl = code;
            end
            wr_issue = (k == 0);
            wr_data = wgen(seed, k);
            wr_mask = mp[2*k +: 2];
        end
    endtask

    // Read burst, scheduling model data, mask and capture expectations.
    task automatic rd_burst(input logic [1:0] code, input logic [15:0] mp, input int n_drive, input int tag);
        int bl;
        bl = nbeats(code);
        for (int k = 0; k < n_drive; k++) begin
            @(negedge clk);
            if (k == 0) begin
                int c;
                c = cyc;
                for (int i = 0; i < lr_n; i++) begin
                    if (lr_c + i >= c) begin
                        rh[ix(lr_c + i)] = 1'b0;
                        dv_v[ix(lr_c + 1 + lr_cl + i)] = 1'b0;
                        em_v[ix(lr_c + lr_cl - 1 + i)] = 1'b0;
                        er_v[ix(lr_c + 2 + lr_cl + i)] = 1'b0;
                    end
                end
                for (int i = 0; i < bl; i++) begin
                    logic [15:0] e;
                    logic [1:0] m;
                    m = mp[2*i +: 2];
                    e = rgen(tag, i);
                    if (m[0]) e[7:0] = 8'h00;
                    if (m[1]) e[15:8] = 8'h00;
                    rh[ix(c + i)] = 1'b1;
                    dv_v[ix(c + 1 + cl + i)] = 1'b1;
                    dv_d[ix(c + 1 + cl + i)] = rgen(tag, i);
                    em_v[ix(c + cl - 1 + i)] = 1'b1;
                    em_m[ix(c + cl - 1 + i)] = m;
                    er_v[ix(c + 2 + cl + i)] = 1'b1;
                    er_d[ix(c + 2 + cl + i)] = e;
                    er_m[ix(c + 2 + cl + i)] = m;
                end
                lr_c = c;
                lr_n = bl;
                lr_cl = cl;
                cfg_bl = code;
            end
            rd_issue = (k == 0);
            rd_mask = mp[2*k +: 2];
        end
    endtask

    initial begin
        logic [15:0] pats [3];
        pats[0] = 16'h0000;
        pats[1] = 16'hE4E4;
        pats[2] = 16'h1B1B;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: all outputs idle while reset is held
        chk(!dq_oe && dq_out == 0 && dqm == 0, "R1 pins in reset", {13'd0, dq_oe, dqm, dq_out}, 32'd0);
        chk(!rd_valid && rd_data == 0 && rd_masked == 0, "R1 user side in reset",
            {13'd0, rd_valid, rd_masked, rd_data}, 32'd0);
        rst_n = 1'b1;
        run_chk = 1'b1;
        idle(4);
        // R2 R3 R4 R5 R6 R9: every latency, burst length and mask pattern
        for (int l = 0; l < 2; l++) begin
            cfg_cl3 = l[0];
            cl = 2 + l;
            for (int b = 0; b < 4; b++) begin
                for (int p = 0; p < 3; p++) begin
                    wr_burst(2'(b), pats[p], nbeats(2'(b)), 16 * b + p + 7 * l);
                    idle(3);
                    rd_burst(2'(b), pats[p], nbeats(2'(b)), 40 + 16 * b + p + 5 * l);
                    idle(9);
                end
            end
            // R4: gapless reads
            rd_burst(2'd2, 16'h0C30, 4, 90 + l);
            rd_burst(2'd2, 16'h00C3, 4, 95 + l);
            idle(10);
            // R8: a second issue cuts each burst short
            wr_burst(2'd3, 16'h3210, 2, 120 + l);
            wr_burst(2'd1, 16'h0006, 2, 130 + l);
            idle(4);
            rd_burst(2'd3, 16'h2121, 3, 140 + l);
            rd_burst(2'd0, 16'h0002, 1, 150 + l);
            idle(10);
        end
        // R7: write overlapping a latency-3 read; first two beats withheld
        cfg_cl3 = 1'b1;
        cl = 3;
        idle(2);
        fork
            rd_burst(2'd2, 16'h0062, 4, 200);
            begin
                repeat (5) @(negedge clk);
                wr_burst(2'd2, 16'h0000, 4, 210);
            end
        join
        idle(12);
        finish_run();
    end

    // Watchdog: a hung run still reaches the summary as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all) act=running exp=finished");
            finish_run();
        end
    end

endmodule